// File: doc/BRIEF.md
# Ethernet Receive Address Filter

This block decides whether a received Ethernet frame is kept or dropped, based only on its 48-bit destination address. The receive path presents the address with a one-cycle strobe; two clock edges later the filter returns a one-cycle decision pulse together with an accept flag.

The decision draws on three sources of match information:
- An own-station address slot that is always active.
- Fifteen extra exact-match slots. Each of these is switched on individually and can ignore chosen address bytes.
- A 64-bit multicast hash table, indexed by six bits of the little-endian CRC-32 of the address.

A control word then applies an override on top of the match result. It can accept everything, accept any multicast, refuse broadcast, or invert the match result.

Configuration uses a plain write port, where each write carries a word index and 32 bits of data. There is no read path.

Top module: `rx_addr_filter`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after its release, `dec_valid` is 0. All configuration words reset to zero.
- R2: Each `da_valid` cycle captured at clock edge k yields exactly one `dec_valid` pulse, which is high for the one cycle after edge k+1. No pulse appears without a captured address.
- R3: Slot 0 (words 16 low / 17 high) is always enabled and never masked. A destination equal to its address is a match.
- R4: Slots 1..15 use word 16+2i (low) and 17+2i (high). A slot matches only while bit 31 of its high word is 1.
- R5: Bits 29:24 of a supplementary slot's high word are a byte mask: bit 24+k set means address byte k is not compared.
- R6: Address byte k is `da_addr[8k+7:8k]` and the first byte on the wire is k=0. Bytes 0..3 sit in bits 31:0 of the low word and bytes 4..5 in bits 15:0 of the high word, in the same order.
- R7: The hash table is word 1 (bits 31:0) and word 2 (bits 63:32). The CRC is the reflected CRC-32 of the six bytes, byte 0 first and least significant bit first, with initial value all ones and the result inverted. Hash bit number {crc[31], crc[30:26]} is the one consulted.
- R8: The hash is consulted only when control bit 2 is set and the address is multicast (byte 0 bit 0 set). A unicast address is never accepted through the hash.
- R9: Control word 0 bit 0 (promiscuous) accepts every frame.
- R10: Control bit 4 accepts every multicast address, whatever the hash and slots say.
- R11: The all-ones broadcast address is accepted unless control bit 5 is set, in which case it is dropped. Promiscuous mode still accepts it.
- R12: Control bit 3 inverts the combined slot/hash match result for non-broadcast frames not covered by R9 or R10.
- R13: A write accepted at the same edge that registers a decision does not change that decision. It does apply to the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| da_valid | input | 1 | Destination address strobe |
| da_addr | input | 48 | Destination address, byte 0 in bits 7:0 |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 6 | Configuration word index |
| cfg_wdata | input | 32 | Configuration write data |
| dec_valid | output | 1 | Decision pulse |
| dec_accept | output | 1 | 1 = keep the frame, valid with `dec_valid` |

## Verification
A configuration write and a decision can meet on the same clock edge.

The bench provokes this by issuing a control write that turns on promiscuous mode in the cycle directly after an address strobe. That write is registered on the very edge that registers the decision for the strobed frame.

The scoreboard expects the frame in flight to be judged under the old settings. It expects an identical frame sent afterwards to be judged under the new settings.

// File: rtl/raf_pkg.sv
// Package: shared constants, control-word type and the address CRC function
// for the receive address filter.
// Assumes a 48-bit address with byte 0 in bits 7:0, the first byte on the wire.
package raf_pkg;

    localparam int MAC_W         = 48;
    localparam int MAC_BYTES     = MAC_W / 8;
    localparam int REG_W         = 32;
    localparam int HASH_W        = 64;
    localparam int HASH_IDX_W    = $clog2(HASH_W);

    // Configuration word indices
    localparam int REG_CTRL      = 0;
    localparam int REG_HASH_LO   = 1;
    localparam int REG_HASH_HI   = 2;
    localparam int REG_SLOT_BASE = 16;

    // Control bit positions
    localparam int B_PROMISC     = 0;
    localparam int B_HASH_EN     = 2;
    localparam int B_INVERT      = 3;
    localparam int B_ALL_MC      = 4;
    localparam int B_REJ_BC      = 5;

    // Slot high-word fields
    localparam int B_SLOT_EN     = 31;
    localparam int B_MASK_LSB    = 24;

    typedef struct packed {
        logic promisc;
        logic all_mc;
        logic hash_en;
        logic rej_bc;
        logic invert;
    } ctrl_t;

    // Reflected CRC-32, init all ones, final inversion, bit 0 of byte 0 first.
    function automatic logic [31:0] addr_crc32(input logic [MAC_W-1:0] d);
        logic [31:0] c;
        c = 32'hFFFF_FFFF;
        for (int i = 0; i < MAC_W; i++) begin
            if (c[0] ^ d[i]) c = (c >> 1) ^ 32'hEDB8_8320;
            else             c = c >> 1;
        end
        return ~c;
    endfunction

endpackage

// File: rtl/raf_cfg_regs.sv
// Module: configuration store of the filter.
// Holds the control word, the 64-bit hash table and the address slots.
// Slot 0 reports itself always enabled and unmasked.
// Writes to unused indices have no effect; there is no read path.
module raf_cfg_regs
    import raf_pkg::*;
#(
    parameter int NUM_SLOTS = 16,
    parameter int ADDR_W    = 6
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            we,
    input  logic [ADDR_W-1:0]               addr,
    input  logic [REG_W-1:0]                wdata,
    output ctrl_t                           ctrl,
    output logic [HASH_W-1:0]               hash,
    output logic [NUM_SLOTS-1:0][MAC_W-1:0] slot_addr,
    output logic [NUM_SLOTS-1:0]            slot_en,
    output logic [NUM_SLOTS-1:0][MAC_BYTES-1:0] slot_mask
);

    ctrl_t             ctrl_q;
    logic [HASH_W-1:0] hash_q;

    // Control word and hash table words
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            hash_q <= '0;
        end else if (we) begin
            if (addr == ADDR_W'(REG_CTRL)) begin
                ctrl_q.promisc <= wdata[B_PROMISC];
                ctrl_q.all_mc  <= wdata[B_ALL_MC];
                ctrl_q.hash_en <= wdata[B_HASH_EN];
                ctrl_q.rej_bc  <= wdata[B_REJ_BC];
                ctrl_q.invert  <= wdata[B_INVERT];
            end
            if (addr == ADDR_W'(REG_HASH_LO)) hash_q[REG_W-1:0]      <= wdata;
            if (addr == ADDR_W'(REG_HASH_HI)) hash_q[HASH_W-1:REG_W] <= wdata;
        end
    end

    assign ctrl = ctrl_q;
    assign hash = hash_q;

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        localparam logic [ADDR_W-1:0] LO_IDX = ADDR_W'(REG_SLOT_BASE + 2 * g);
        localparam logic [ADDR_W-1:0] HI_IDX = ADDR_W'(REG_SLOT_BASE + 2 * g + 1);
        logic [MAC_W-1:0] a_q;

        // Slot address bytes: low word bytes 0..3, high word bytes 4..5
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                a_q <= '0;
            end else if (we) begin
                if (addr == LO_IDX) a_q[REG_W-1:0]     <= wdata;
                if (addr == HI_IDX) a_q[MAC_W-1:REG_W] <= wdata[MAC_W-REG_W-1:0];
            end
        end
        assign slot_addr[g] = a_q;

        if (g == 0) begin : g_own
            assign slot_en[g]   = 1'b1;
            assign slot_mask[g] = '0;
        end else begin : g_sup
            logic                 en_q;
            logic [MAC_BYTES-1:0] m_q;

            // Enable bit and byte mask of a supplementary slot
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    en_q <= 1'b0;
                    m_q  <= '0;
                end else if (we && addr == HI_IDX) begin
                    en_q <= wdata[B_SLOT_EN];
                    m_q  <= wdata[B_MASK_LSB +: MAC_BYTES];
                end
            end
            assign slot_en[g]   = en_q;
            assign slot_mask[g] = m_q;
        end
    end

endmodule

// File: rtl/raf_slot_match.sv
// Module: exact-match comparison of one address against all slots.
// A slot hits when it is enabled and every byte it does not mask is equal.
// Purely combinational.
module raf_slot_match
    import raf_pkg::*;
#(
    parameter int NUM_SLOTS = 16
) (
    input  logic [MAC_W-1:0]                    da,
    input  logic [NUM_SLOTS-1:0][MAC_W-1:0]     slot_addr,
    input  logic [NUM_SLOTS-1:0]                slot_en,
    input  logic [NUM_SLOTS-1:0][MAC_BYTES-1:0] slot_mask,
    output logic                                hit
);

    logic [NUM_SLOTS-1:0] slot_hit;

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_cmp
        logic [MAC_BYTES-1:0] byte_ok;
        for (genvar b = 0; b < MAC_BYTES; b++) begin : g_byte
            assign byte_ok[b] = slot_mask[g][b] ||
                                (da[8*b +: 8] == slot_addr[g][8*b +: 8]);
        end
        assign slot_hit[g] = slot_en[g] && (&byte_ok);
    end

    assign hit = |slot_hit;

endmodule

// File: rtl/raf_decide.sv
// Module: final accept decision from the slot hit, the hash and the control word.
// The precedence is: promiscuous, then broadcast, then all-multicast,
// then the optionally inverted slot/hash match. Purely combinational.
module raf_decide
    import raf_pkg::*;
(
    input  logic [MAC_W-1:0]  da,
    input  logic              slot_hit,
    input  ctrl_t             ctrl,
    input  logic [HASH_W-1:0] hash,
    output logic              accept
);

    logic [31:0]           crc;
    logic [HASH_IDX_W-1:0] hidx;
    logic                  is_mc, is_bc, hash_hit, match;

    assign crc      = addr_crc32(da);
    assign hidx     = crc[31 -: HASH_IDX_W];
    assign is_mc    = da[0];
    assign is_bc    = &da;
    assign hash_hit = ctrl.hash_en && is_mc && hash[hidx];
    assign match    = (slot_hit || hash_hit) ^ ctrl.invert;

    // Precedence chain of the filter modes
    always_comb begin
        if (ctrl.promisc)              accept = 1'b1;
        else if (is_bc)                accept = !ctrl.rej_bc;
        else if (is_mc && ctrl.all_mc) accept = 1'b1;
        else                           accept = match;
    end

endmodule

// File: rtl/rx_addr_filter.sv
// Module: receive destination-address filter, top level.
// Edge k captures the address. The match is then evaluated against the
// configuration as it stands after edge k, and the decision is registered
// at edge k+1.
module rx_addr_filter
    import raf_pkg::*;
#(
    parameter int NUM_SLOTS = 16,
    parameter int ADDR_W    = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              da_valid,
    input  logic [47:0]       da_addr,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [31:0]       cfg_wdata,
    output logic              dec_valid,
    output logic              dec_accept
);

    ctrl_t                               ctrl;
    logic [HASH_W-1:0]                   hash;
    logic [NUM_SLOTS-1:0][MAC_W-1:0]     slot_addr;
    logic [NUM_SLOTS-1:0]                slot_en;
    logic [NUM_SLOTS-1:0][MAC_BYTES-1:0] slot_mask;
    logic [MAC_W-1:0]                    da_q;
    logic                                vld_q, hit, accept;

    raf_cfg_regs #(.NUM_SLOTS(NUM_SLOTS), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
        .ctrl(ctrl), .hash(hash), .slot_addr(slot_addr), .slot_en(slot_en),
        .slot_mask(slot_mask)
    );

    // Capture stage for the incoming address
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= 1'b0;
            da_q  <= '0;
        end else begin
            vld_q <= da_valid;
            if (da_valid) da_q <= da_addr;
        end
    end

    raf_slot_match #(.NUM_SLOTS(NUM_SLOTS)) u_match (
        .da(da_q), .slot_addr(slot_addr), .slot_en(slot_en),
        .slot_mask(slot_mask), .hit(hit)
    );

    raf_decide u_decide (
        .da(da_q), .slot_hit(hit), .ctrl(ctrl), .hash(hash), .accept(accept)
    );

    // Decision output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_valid  <= 1'b0;
            dec_accept <= 1'b0;
        end else begin
            dec_valid  <= vld_q;
            dec_accept <= vld_q && accept;
        end
    end

endmodule

// File: rtl/rx_addr_filter_chk.sv
// Module: assertion checker bound to rx_addr_filter.
// It watches the ports and the configuration state.
module rx_addr_filter_chk
    import raf_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             da_valid,
    input logic [MAC_W-1:0] da_addr,
    input logic             cfg_we,
    input logic             dec_valid,
    input logic             dec_accept,
    input ctrl_t            ctrl,
    input logic [MAC_W-1:0] own_addr
);

    // R1
    rst_quiet_chk: assert property (@(posedge clk) !rst_n |=> !dec_valid);

    // R2
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        da_valid |-> ##2 dec_valid);

    // R9
    promisc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (da_valid && ctrl.promisc && !cfg_we) |-> ##2 dec_accept);

    // R11
    bcast_rej_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (da_valid && (&da_addr) && ctrl.rej_bc && !ctrl.promisc && !cfg_we)
        |-> ##2 !dec_accept);

    // R3
    own_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (da_valid && da_addr == own_addr && !ctrl.invert && !(&da_addr) && !cfg_we)
        |-> ##2 dec_accept);

endmodule

bind rx_addr_filter rx_addr_filter_chk u_chk (
    .clk(clk), .rst_n(rst_n), .da_valid(da_valid), .da_addr(da_addr),
    .cfg_we(cfg_we), .dec_valid(dec_valid), .dec_accept(dec_accept),
    .ctrl(ctrl), .own_addr(slot_addr[0])
);

// File: tb/rx_addr_filter_tb.sv
// Scoreboard bench for rx_addr_filter. The driver computes expected
// decisions from a shadow of the configuration; the monitor compares them.
module rx_addr_filter_tb;

    typedef struct {
        logic  acc;
        int    cyc;
        string tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        da_valid = 1'b0;
    logic [47:0] da_addr = '0;
    logic        cfg_we = 1'b0;
    logic [5:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        dec_valid, dec_accept;

    int   total = 0, bad = 0, cyc = 0;
    bit   done = 0;
    exp_t sb[$];

    // shadow configuration
    logic [31:0] s_ctrl = '0;
    logic [63:0] s_hash = '0;
    logic [47:0] s_addr[16];
    logic        s_en[16];
    logic [5:0]  s_mask[16];

    rx_addr_filter u_dut (
        .clk(clk), .rst_n(rst_n), .da_valid(da_valid), .da_addr(da_addr),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .dec_valid(dec_valid), .dec_accept(dec_accept)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [31:0] ref_crc(input logic [47:0] a);
        logic [31:0] c = 32'hFFFFFFFF;
        for (int b = 0; b < 6; b++) begin
            c = c ^ {24'h0, a[8*b +: 8]};
            for (int k = 0; k < 8; k++)
                c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
        end
        return ~c;
    endfunction

    function automatic logic [5:0] hidx(input logic [47:0] a);
        logic [31:0] c = ref_crc(a);
        return {c[31], c[30:26]};
    endfunction

    function automatic logic model(input logic [47:0] a);
        logic hit = 0, ok, m;
        logic mc = a[0];
        logic bc = (a == 48'hFFFFFFFFFFFF);
        for (int i = 0; i < 16; i++) begin
            ok = (i == 0) || s_en[i];
            for (int b = 0; b < 6; b++)
                if (!(i != 0 && s_mask[i][b]) && a[8*b +: 8] != s_addr[i][8*b +: 8]) ok = 0;
            if (ok) hit = 1;
        end
        m = (hit || (s_ctrl[2] && mc && s_hash[hidx(a)])) ^ s_ctrl[3];
        if (s_ctrl[0]) return 1'b1;
        if (bc)        return !s_ctrl[5];
        if (mc && s_ctrl[4]) return 1'b1;
        return m;
    endfunction

    // driver: configuration write (called at a negedge)
    task automatic wr(input int idx, input logic [31:0] d);
        cfg_we = 1; cfg_addr = 6'(idx); cfg_wdata = d;
        if (idx == 0) s_ctrl = d;
        if (idx == 1) s_hash[31:0] = d;
        if (idx == 2) s_hash[63:32] = d;
        if (idx >= 16 && idx < 48) begin
            if (idx % 2 == 0) s_addr[(idx-16)/2][31:0] = d;
            else begin
                s_addr[(idx-16)/2][47:32] = d[15:0];
                s_en[(idx-16)/2]   = d[31];
                s_mask[(idx-16)/2] = d[29:24];
            end
        end
        @(posedge clk);
        @(negedge clk);
        cfg_we = 0;
    endtask

    task automatic set_slot(input int i, input logic [47:0] a, input logic en, input logic [5:0] m);
        wr(16 + 2*i, a[31:0]);
        wr(17 + 2*i, {en, 1'b0, m, 8'h00, a[47:32]});
    endtask

    // driver: one address strobe, expected result pushed to the scoreboard
    task automatic send(input logic [47:0] a, input string tag);
        exp_t e;
        da_valid = 1; da_addr = a;
        e.acc = model(a); e.tag = tag;
        @(posedge clk);
        #0 e.cyc = cyc + 1;
        sb.push_back(e);
        @(negedge clk);
        da_valid = 0;
    endtask

    // monitor: pop and compare each decision
    always @(negedge clk) begin
        if (rst_n && dec_valid) begin
            exp_t e;
            total++;
            if (sb.size() == 0) begin
                bad++;
                $display("FAIL R2 unexpected decision act=1 exp=0");
            end else begin
                e = sb.pop_front();
                if (dec_accept !== e.acc || cyc != e.cyc + 1) begin
                    bad++;
                    $display("FAIL %s accept=%0d exp=%0d cyc=%0d expcyc=%0d",
                             e.tag, dec_accept, e.acc, cyc, e.cyc + 1);
                end
            end
        end
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        logic [47:0] own, mcA, mcB;
        for (int i = 0; i < 16; i++) begin
            s_addr[i] = '0; s_en[i] = 0; s_mask[i] = '0;
        end
        repeat (3) @(negedge clk);
        total++;
        if (dec_valid !== 1'b0) begin bad++; $display("FAIL R1 dec_valid=%0d exp=0", dec_valid); end
        rst_n = 1;
        @(negedge clk);
        total++;
        if (dec_valid !== 1'b0) begin bad++; $display("FAIL R1 dec_valid=%0d exp=0", dec_valid); end

        // R1: all-zero reset slot 0 matches the zero address
        send(48'h0, "R1");
        // R3, R6: own address, byte 0 = 0x02 in bits 7:0
        own = 48'h5544_3322_1102;
        set_slot(0, own, 0, 6'h3F);
        send(own, "R3");
        send(48'h5544_3322_1103, "R6");
        send(48'h0255_4433_2211, "R6");
        // R4: disabled supplementary slot never matches, then enabled
        set_slot(3, 48'hAABB_CCDD_EE10, 0, 0);
        send(48'hAABB_CCDD_EE10, "R4");
        set_slot(3, 48'hAABB_CCDD_EE10, 1, 0);
        send(48'hAABB_CCDD_EE10, "R4");
        // R5: prefix match 01:00:5e with bytes 3..5 masked
        set_slot(5, 48'h0000_005E_0001, 1, 6'b111000);
        send(48'h5634_125E_0001, "R5");
        send(48'h5634_125F_0001, "R5");
        // R7, R8: hash lookup
        mcA = 48'h0100_0000_3333;
        mcB = 48'h0200_0000_3333;
        begin
            logic [5:0] ia = hidx(mcA);
            if (hidx(mcB) == ia) mcB = 48'h0300_0000_3333;
            if (ia[5]) wr(2, 32'h1 << ia[4:0]); else wr(1, 32'h1 << ia[4:0]);
        end
        send(mcA, "R8");
        wr(0, 32'h4);
        send(mcA, "R7");
        send(mcB, "R7");
        wr(1, 32'hFFFFFFFF); wr(2, 32'hFFFFFFFF);
        send(48'h0100_0000_3334, "R8");
        send(48'h0100_0000_3335, "R8");
        wr(1, 0); wr(2, 0);
        // R10: all multicast
        wr(0, 32'h10);
        send(mcB, "R10");
        send(48'h0100_0000_3334, "R10");
        // R11: broadcast
        wr(0, 32'h0);
        send(48'hFFFF_FFFF_FFFF, "R11");
        wr(0, 32'h20);
        send(48'hFFFF_FFFF_FFFF, "R11");
        wr(0, 32'h21);
        send(48'hFFFF_FFFF_FFFF, "R11");
        // R9: promiscuous
        wr(0, 32'h1);
        send(48'h1234_5678_9ABC, "R9");
        // R12: inverse matching
        wr(0, 32'h8);
        send(own, "R12");
        send(48'h1234_5678_9ABC, "R12");
        // R13: write on the decision edge affects only the next frame
        wr(0, 32'h0);
        send(48'h1234_5678_9ABC, "R13");
        wr(0, 32'h1);
        send(48'h1234_5678_9ABC, "R13");
        // R2: back-to-back strobes
        wr(0, 32'h0);
        send(own, "R2");
        send(48'h1234_5678_9ABC, "R2");
        send(own, "R2");
        repeat (4) @(negedge clk);
        total++;
        if (sb.size() != 0) begin bad++; $display("FAIL R2 pending=%0d exp=0", sb.size()); end
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule